// File: doc/BRIEF.md
# Nibble-Split Index Register Unit

This unit keeps two 12-bit index registers, X and Y, each cut into three 4-bit fields: page (bits 11:8), high (bits 7:4) and low (bits 3:0). It runs one decoded operation at a time on them. It can step a whole register by one, load high and low together from an 8-bit immediate, move any single field to or from a 4-bit general register value, and add a 4-bit immediate plus a carry-in into one high or low field. Only that add touches the zero and carry flags.

Operations come in over a valid/ready handshake. The producer holds `op_valid_i` and its operands steady until it sees `op_ready_o` high at a rising clock edge, and the operation is taken at that edge. The unit then drops `op_ready_o` for as long as the operation runs. It applies back-pressure by ignoring whatever is on the operation inputs during that time. When the operation ends, the register contents, flags and read value update together, and `done_o` pulses for one cycle.

Top module: `ixr_unit`

## Requirements
- R1: While `rst_ni` is low, X, Y, `rd_o`, `zf_o`, `cf_o` and `done_o` are all zero and `op_ready_o` is high.
- R2: An operation is accepted at a clock edge where `op_valid_i` and `op_ready_o` are both high. `op_ready_o` is then low for the next LAT-1 cycles, and operation inputs presented in those cycles are ignored. Registers, flags and `rd_o` change only at the edge that completes an operation.
- R3: LAT is 7 for a legal add-with-carry and 5 for every other code, reserved codes included. Results appear, and `done_o` is high for exactly one cycle, in the cycle after the LAT cycles that start with the accept cycle. `op_ready_o` is high again in that same cycle.
- R4: Increment adds one to the whole selected register modulo 4096, so 0xFFF wraps to 0x000 and carries run across the field boundaries. The other register is unchanged.
- R5: Immediate load writes `op_imm_i[7:4]` to the high field (bits 7:4) and `op_imm_i[3:0]` to the low field (bits 3:0). The page field (bits 11:8) keeps its value. The field code is ignored.
- R6: Field write copies `op_reg_i` into the selected field. Field code 0 selects low (3:0), 1 selects high (7:4) and 2 selects page (11:8). All other bits stay unchanged.
- R7: Field read places the selected field (same field codes) on `rd_o` and changes no register. `rd_o` changes only on a field read.
- R8: Add-with-carry on the high (code 1) or low (code 0) field forms field + `op_imm_i[3:0]` + `carry_i`. The field takes the low 4 bits of that sum, `cf_o` takes bit 4, and `zf_o` is set when the 4-bit result is zero. No other field changes, so nothing carries into a neighbour.
- R9: Increment, load, field write, field read and reserved codes leave `zf_o` and `cf_o` unchanged.
- R10: `op_code_i[5:3]` is the kind: 0 increment, 1 load, 2 field write, 3 field read, 4 add-with-carry. `op_code_i[2]` selects Y when set and X when clear, and `op_code_i[1:0]` is the field code. Kinds 5 to 7, field code 3 for write or read, and field codes 2 and 3 for add-with-carry are reserved. A reserved code changes no register, flag or `rd_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation offered |
| op_ready_o | output | 1 | Unit can take an operation |
| op_code_i | input | 6 | Kind, register select and field code |
| op_reg_i | input | 4 | General register value for field writes |
| op_imm_i | input | 8 | Immediate for loads and add-with-carry |
| carry_i | input | 1 | Carry-in for add-with-carry |
| x_o | output | 12 | Contents of X |
| y_o | output | 12 | Contents of Y |
| rd_o | output | 4 | Value of the last field read |
| zf_o | output | 1 | Zero flag |
| cf_o | output | 1 | Carry flag |
| done_o | output | 1 | One-cycle pulse when an operation finishes |

## Verification
The add-with-carry is tried over every field value, immediate and carry-in, on the low field of X and the high field of Y. The other fields are preloaded with distinct nonzero values, so a carry that leaks into a neighbour or lands in the wrong register shows up. Every field of both registers is written and read back with all sixteen values, which tells the three field positions apart. Increments start just below 0xFFF and just below a nibble boundary, which separates correct wrap and carry from per-field counting. Reserved codes and operations offered during a busy window are issued with nonzero flags already set, so any stray update to a flag or register is visible.

// File: rtl/ixr_pkg.sv
package ixr_pkg;

  localparam logic [2:0] KIND_INC = 3'd0;
  localparam logic [2:0] KIND_LDI = 3'd1;
  localparam logic [2:0] KIND_WR  = 3'd2;
  localparam logic [2:0] KIND_RD  = 3'd3;
  localparam logic [2:0] KIND_ADC = 3'd4;

  localparam logic [1:0] FLD_LO = 2'd0;
  localparam logic [1:0] FLD_HI = 2'd1;
  localparam logic [1:0] FLD_PG = 2'd2;

  typedef struct packed {
    logic       legal;
    logic [2:0] kind;
    logic       sel_y;
    logic [1:0] fld;
    logic       long_op;
  } ixr_cmd_t;

endpackage

// File: rtl/ixr_decode.sv
module ixr_decode
  import ixr_pkg::*;
(
  input  logic [5:0] code_i,
  output ixr_cmd_t   cmd_o
);
  logic [2:0] kind;
  logic [1:0] fld;
  logic       legal;

  assign kind = code_i[5:3];
  assign fld  = code_i[1:0];

  always_comb begin
    unique case (kind)
      KIND_INC, KIND_LDI: legal = 1'b1;
      KIND_WR,  KIND_RD:  legal = (fld != 2'd3);
      KIND_ADC:           legal = (fld == FLD_LO) || (fld == FLD_HI);
      default:            legal = 1'b0;
    endcase
  end

  always_comb begin
    cmd_o.legal   = legal;
    cmd_o.kind    = kind;
    cmd_o.sel_y   = code_i[2];
    cmd_o.fld     = fld;
    cmd_o.long_op = legal && (kind == KIND_ADC);
  end
endmodule

// File: rtl/ixr_seq.sv
module ixr_seq #(
  parameter int LAT_SHORT = 5,
  parameter int LAT_LONG  = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic long_i,
  output logic ready_o,
  output logic accept_o,
  output logic commit_o
);
  localparam int CW = $clog2(LAT_LONG) + 1;

  logic [CW-1:0] cnt_q;
  logic          long_q;
  logic [CW-1:0] age_q;

  assign ready_o  = (cnt_q == '0);
  assign accept_o = valid_i && ready_o;
  assign commit_o = (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      long_q <= 1'b0;
    end else if (accept_o) begin
      cnt_q  <= long_i ? CW'(LAT_LONG - 1) : CW'(LAT_SHORT - 1);
      long_q <= long_i;
    end else if (!ready_o) begin
      cnt_q  <= cnt_q - CW'(1);
    end
  end

  // cycles elapsed since the accept edge, used by the latency check
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        age_q <= '0;
    else if (accept_o)  age_q <= CW'(1);
    else if (!ready_o)  age_q <= age_q + CW'(1);
  end

  AST_BUSY_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !ready_o); // R2
  AST_SINGLE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o && ready_o); // R3
  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> age_q == (long_q ? CW'(LAT_LONG - 1) : CW'(LAT_SHORT - 1))); // R3
endmodule

// File: rtl/ixr_field_alu.sv
module ixr_field_alu #(
  parameter int FW = 4
) (
  input  logic [FW-1:0] a_i,
  input  logic [FW-1:0] b_i,
  input  logic          cin_i,
  output logic [FW-1:0] sum_o,
  output logic          cout_o,
  output logic          zero_o
);
  logic [FW:0] full;

  assign full   = {1'b0, a_i} + {1'b0, b_i} + {{FW{1'b0}}, cin_i};
  assign sum_o  = full[FW-1:0];
  assign cout_o = full[FW];
  assign zero_o = (full[FW-1:0] == '0);
endmodule

// File: rtl/ixr_reg_next.sv
module ixr_reg_next
  import ixr_pkg::*;
#(
  parameter int FW = 4,
  parameter int RW = 3 * FW
) (
  input  logic [RW-1:0]   cur_i,
  input  logic            hit_i,
  input  logic [2:0]      kind_i,
  input  logic [1:0]      fld_i,
  input  logic [FW-1:0]   reg_i,
  input  logic [2*FW-1:0] imm_i,
  input  logic [FW-1:0]   sum_i,
  output logic [RW-1:0]   nxt_o
);
  logic [RW-1:0] fld_put;

  // cur_i with the addressed field replaced by a 4-bit value
  function automatic logic [RW-1:0] put_field(logic [RW-1:0] r, logic [1:0] f,
                                              logic [FW-1:0] v);
    logic [RW-1:0] o;
    o = r;
    unique case (f)
      FLD_LO:  o[FW-1:0]      = v;
      FLD_HI:  o[2*FW-1:FW]   = v;
      FLD_PG:  o[RW-1:2*FW]   = v;
      default: o = r;
    endcase
    return o;
  endfunction

  always_comb begin
    fld_put = cur_i;
    if (kind_i == KIND_WR)       fld_put = put_field(cur_i, fld_i, reg_i);
    else if (kind_i == KIND_ADC) fld_put = put_field(cur_i, fld_i, sum_i);
  end

  always_comb begin
    nxt_o = cur_i;
    if (hit_i) begin
      unique case (kind_i)
        KIND_INC: nxt_o = cur_i + RW'(1);
        KIND_LDI: nxt_o = {cur_i[RW-1:2*FW], imm_i};
        KIND_WR,
        KIND_ADC: nxt_o = fld_put;
        default:  nxt_o = cur_i;
      endcase
    end
  end
endmodule

// File: rtl/ixr_unit.sv
module ixr_unit
  import ixr_pkg::*;
#(
  parameter int FW        = 4,
  parameter int LAT_SHORT = 5,
  parameter int LAT_LONG  = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                op_valid_i,
  output logic                op_ready_o,
  input  logic [5:0]          op_code_i,
  input  logic [FW-1:0]       op_reg_i,
  input  logic [2*FW-1:0]     op_imm_i,
  input  logic                carry_i,
  output logic [3*FW-1:0]     x_o,
  output logic [3*FW-1:0]     y_o,
  output logic [FW-1:0]       rd_o,
  output logic                zf_o,
  output logic                cf_o,
  output logic                done_o
);
  localparam int NREG = 2;
  localparam int RW   = 3 * FW;
  localparam int IW   = 2 * FW;

  ixr_cmd_t      cmd_in, cmd_q;
  logic [FW-1:0] reg_q;
  logic [IW-1:0] imm_q;
  logic          cin_q;
  logic          accept, commit;

  logic [RW-1:0] ireg_q [NREG];
  logic [RW-1:0] ireg_d [NREG];
  logic [RW-1:0] cur_sel;
  logic [FW-1:0] fld_val;
  logic [FW-1:0] alu_sum;
  logic          alu_cout, alu_zero;
  logic [FW-1:0] rd_q;
  logic          zf_q, cf_q, done_q;

  ixr_decode u_dec (
    .code_i (op_code_i),
    .cmd_o  (cmd_in)
  );

  ixr_seq #(
    .LAT_SHORT (LAT_SHORT),
    .LAT_LONG  (LAT_LONG)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (op_valid_i),
    .long_i   (cmd_in.long_op),
    .ready_o  (op_ready_o),
    .accept_o (accept),
    .commit_o (commit)
  );

  // operands are captured at acceptance and used at completion
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      reg_q <= '0;
      imm_q <= '0;
      cin_q <= 1'b0;
    end else if (accept) begin
      cmd_q <= cmd_in;
      reg_q <= op_reg_i;
      imm_q <= op_imm_i;
      cin_q <= carry_i;
    end
  end

  assign cur_sel = cmd_q.sel_y ? ireg_q[1] : ireg_q[0];

  always_comb begin
    unique case (cmd_q.fld)
      FLD_LO:  fld_val = cur_sel[FW-1:0];
      FLD_HI:  fld_val = cur_sel[2*FW-1:FW];
      FLD_PG:  fld_val = cur_sel[RW-1:2*FW];
      default: fld_val = '0;
    endcase
  end

  ixr_field_alu #(.FW(FW)) u_alu (
    .a_i    (fld_val),
    .b_i    (imm_q[FW-1:0]),
    .cin_i  (cin_q),
    .sum_o  (alu_sum),
    .cout_o (alu_cout),
    .zero_o (alu_zero)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_ireg
    logic hit;
    assign hit = cmd_q.legal && (cmd_q.sel_y == (g == 1));

    ixr_reg_next #(.FW(FW), .RW(RW)) u_next (
      .cur_i  (ireg_q[g]),
      .hit_i  (hit),
      .kind_i (cmd_q.kind),
      .fld_i  (cmd_q.fld),
      .reg_i  (reg_q),
      .imm_i  (imm_q),
      .sum_i  (alu_sum),
      .nxt_o  (ireg_d[g])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     ireg_q[g] <= '0;
      else if (commit) ireg_q[g] <= ireg_d[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zf_q   <= 1'b0;
      cf_q   <= 1'b0;
      rd_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= commit;
      if (commit && cmd_q.legal) begin
        if (cmd_q.kind == KIND_ADC) begin
          zf_q <= alu_zero;
          cf_q <= alu_cout;
        end
        if (cmd_q.kind == KIND_RD) rd_q <= fld_val;
      end
    end
  end

  assign x_o    = ireg_q[0];
  assign y_o    = ireg_q[1];
  assign rd_o   = rd_q;
  assign zf_o   = zf_q;
  assign cf_o   = cf_q;
  assign done_o = done_q;

  AST_QUIET_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> $stable(x_o) && $stable(y_o) && $stable(zf_o) && $stable(cf_o)
             && $stable(rd_o)); // R2
  AST_INC_STEP_X: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit && cmd_q.kind == KIND_INC && !cmd_q.sel_y
      |=> x_o == $past(x_o) + RW'(1) && $stable(y_o)); // R4
  AST_LOAD_KEEPS_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit && cmd_q.kind == KIND_LDI
      |=> $stable(x_o[RW-1:2*FW]) && $stable(y_o[RW-1:2*FW])); // R5
  AST_READ_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit && cmd_q.kind == KIND_RD |=> $stable(x_o) && $stable(y_o)); // R7
  AST_RD_ONLY_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit && cmd_q.kind != KIND_RD |=> $stable(rd_o)); // R7
  AST_ADC_NO_SPILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit && cmd_q.kind == KIND_ADC && cmd_q.fld == FLD_LO
      |=> $stable(x_o[RW-1:FW]) && $stable(y_o[RW-1:FW])); // R8
  AST_FLAGS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit && cmd_q.kind != KIND_ADC |=> $stable(zf_o) && $stable(cf_o)); // R9
  AST_RESERVED_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit && !cmd_q.legal |=> $stable(x_o) && $stable(y_o) && $stable(zf_o)
                              && $stable(cf_o)); // R10
endmodule

// File: tb/test_ixr_unit.sv
`timescale 1ns/1ps
module test_ixr_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        op_valid_i = 1'b0;
  logic        op_ready_o;
  logic [5:0]  op_code_i = '0;
  logic [3:0]  op_reg_i = '0;
  logic [7:0]  op_imm_i = '0;
  logic        carry_i = 1'b0;
  logic [11:0] x_o, y_o;
  logic [3:0]  rd_o;
  logic        zf_o, cf_o, done_o;

  int n_chk = 0;
  int n_err = 0;
  logic [11:0] mx = '0, my = '0;
  logic        mz = 1'b0, mc = 1'b0;
  logic [3:0]  mrd = '0;

  always #2.5 clk_i = ~clk_i;

  ixr_unit i_ixr_unit (
    .clk_i, .rst_ni, .op_valid_i, .op_ready_o, .op_code_i, .op_reg_i,
    .op_imm_i, .carry_i, .x_o, .y_o, .rd_o, .zf_o, .cf_o, .done_o
  );

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [3:0] fget(logic [11:0] r, int f);
    return r[f*4 +: 4];
  endfunction

  function automatic logic [11:0] fset(logic [11:0] r, int f, logic [3:0] v);
    logic [11:0] o;
    o = r;
    o[f*4 +: 4] = v;
    return o;
  endfunction

  // reference model from the requirements; returns expected latency
  function automatic int model(logic [5:0] code, logic [3:0] rv, logic [7:0] imm,
                               logic c);
    int kind, f;
    logic [11:0] cur;
    logic [4:0] s;
    kind = int'(code[5:3]);
    f    = int'(code[1:0]);
    cur  = code[2] ? my : mx;
    case (kind)
      0: cur = cur + 12'd1;
      1: cur = {cur[11:8], imm};
      2: if (f < 3) cur = fset(cur, f, rv);
      3: if (f < 3) mrd = fget(cur, f);
      4: if (f < 2) begin
           s   = {1'b0, fget(cur, f)} + {1'b0, imm[3:0]} + {4'b0, c};
           cur = fset(cur, f, s[3:0]);
           mc  = s[4];
           mz  = (s[3:0] == 4'd0);
         end
      default: ;
    endcase
    if (code[2]) my = cur; else mx = cur;
    return (kind == 4 && f < 2) ? 7 : 5;
  endfunction

  task automatic run(logic [5:0] code, logic [3:0] rv, logic [7:0] imm, logic c,
                     string rq, bit noise = 1'b0);
    int lat, n;
    lat = model(code, rv, imm, c);
    @(negedge clk_i);
    chk(op_ready_o == 1'b1, "R2", "ready before offer", int'(op_ready_o), 1);
    op_valid_i = 1'b1; op_code_i = code; op_reg_i = rv; op_imm_i = imm; carry_i = c;
    @(negedge clk_i);
    chk(op_ready_o == 1'b0, "R2", "ready after accept", int'(op_ready_o), 0);
    if (noise) begin
      op_code_i = 6'b000_100; op_reg_i = 4'h9; op_imm_i = 8'hFF; carry_i = 1'b1;
    end else begin
      op_valid_i = 1'b0;
    end
    n = 2;
    while (!done_o && n < 20) begin
      @(negedge clk_i);
      n++;
    end
    op_valid_i = 1'b0;
    chk(n - 1 == lat, "R3", "occupancy cycles", n - 1, lat);
    chk(op_ready_o == 1'b1, "R3", "ready with done", int'(op_ready_o), 1);
    chk(x_o == mx, rq, "X", int'(x_o), int'(mx));
    chk(y_o == my, rq, "Y", int'(y_o), int'(my));
    chk(rd_o == mrd, rq, "read value", int'(rd_o), int'(mrd));
    chk(zf_o == mz, (code[5:3] == 3'd4) ? rq : "R9", "zero flag", int'(zf_o), int'(mz));
    chk(cf_o == mc, (code[5:3] == 3'd4) ? rq : "R9", "carry flag", int'(cf_o), int'(mc));
    @(negedge clk_i);
    chk(done_o == 1'b0, "R3", "done one cycle", int'(done_o), 0);
  endtask

  function automatic logic [5:0] opc(int kind, int sy, int f);
    return {3'(kind), 1'(sy), 2'(f)};
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=expired expected=finished");
    summary();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk_i);
    chk(x_o == 12'h000 && y_o == 12'h000, "R1", "regs in reset", int'({x_o, y_o}), 0);
    chk(rd_o == 4'h0 && !zf_o && !cf_o && !done_o, "R1", "outputs in reset",
        int'({rd_o, zf_o, cf_o, done_o}), 0);
    chk(op_ready_o == 1'b1, "R1", "ready in reset", int'(op_ready_o), 1);
    rst_ni = 1'b1;

    // R6 / R7: every field of both registers, all values, written then read back
    for (int sy = 0; sy < 2; sy++)
      for (int f = 0; f < 3; f++)
        for (int v = 0; v < 16; v++) begin
          run(opc(2, sy, f), 4'(v), 8'h00, 1'b0, "R6");
          run(opc(3, sy, f), 4'h0, 8'h00, 1'b0, "R7");
        end

    // R5: immediate load keeps page
    run(opc(2, 0, 2), 4'hA, 8'h00, 1'b0, "R6");
    run(opc(2, 1, 2), 4'h5, 8'h00, 1'b0, "R6");
    for (int v = 0; v < 256; v += 17) begin
      run(opc(1, 0, v % 4), 4'h0, 8'(v), 1'b0, "R5");
      run(opc(1, 1, 3 - (v % 4)), 4'h0, 8'(255 - v), 1'b0, "R5");
    end

    // R4: increment across nibble carry and wrap
    run(opc(2, 0, 2), 4'hF, 8'h00, 1'b0, "R6");
    run(opc(1, 0, 0), 4'h0, 8'hFD, 1'b0, "R5");
    for (int k = 0; k < 5; k++) run(opc(0, 0, 0), 4'h0, 8'h00, 1'b0, "R4");
    run(opc(2, 1, 2), 4'h0, 8'h00, 1'b0, "R6");
    run(opc(1, 1, 0), 4'h0, 8'hFE, 1'b0, "R5");
    for (int k = 0; k < 3; k++) run(opc(0, 1, 0), 4'h0, 8'h00, 1'b0, "R4");

    // R8: exhaustive add-with-carry on X low and Y high, neighbours nonzero
    run(opc(2, 0, 2), 4'hA, 8'h00, 1'b0, "R6");
    run(opc(2, 0, 1), 4'h5, 8'h00, 1'b0, "R6");
    run(opc(2, 1, 2), 4'h6, 8'h00, 1'b0, "R6");
    run(opc(2, 1, 0), 4'h9, 8'h00, 1'b0, "R6");
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int c = 0; c < 2; c++) begin
          run(opc(2, 0, 0), 4'(a), 8'h00, 1'b0, "R6");
          run(opc(4, 0, 0), 4'h0, {4'(15 - b), 4'(b)}, 1'(c), "R8");
          run(opc(2, 1, 1), 4'(a), 8'h00, 1'b0, "R6");
          run(opc(4, 1, 1), 4'h0, 8'(b), 1'(c), "R8");
        end

    // R9 / R10: set both flags, then reserved codes and flag-neutral ops
    run(opc(2, 0, 0), 4'h0, 8'h00, 1'b0, "R6");
    run(opc(4, 0, 0), 4'h0, 8'h0F, 1'b1, "R8");
    chk(zf_o && cf_o, "R8", "flags set for R10 test", int'({zf_o, cf_o}), 3);
    for (int k = 5; k < 8; k++) run(opc(k, k % 2, k % 4), 4'h7, 8'h33, 1'b1, "R10");
    run(opc(2, 0, 3), 4'h7, 8'h33, 1'b1, "R10");
    run(opc(3, 1, 3), 4'h7, 8'h33, 1'b1, "R10");
    run(opc(4, 0, 2), 4'h7, 8'h33, 1'b1, "R10");
    run(opc(4, 1, 3), 4'h7, 8'h33, 1'b1, "R10");
    run(opc(0, 0, 0), 4'h0, 8'h00, 1'b1, "R9");
    run(opc(1, 1, 0), 4'h0, 8'h12, 1'b1, "R9");
    run(opc(2, 1, 2), 4'h3, 8'h00, 1'b1, "R9");

    // R2: operation held on inputs during busy window is not taken
    run(opc(2, 1, 0), 4'h4, 8'h00, 1'b0, "R2", 1'b1);
    run(opc(4, 0, 1), 4'h0, 8'h0B, 1'b1, "R2", 1'b1);

    summary();
  end
endmodule